// File: doc/BRIEF.md
# Glitch-Free Switchable Clock Prescaler

This block takes the undivided input clock and produces one system clock that feeds the processor, the synchronous peripherals and the non-volatile memory interface together. A 3-bit code selects a power-of-two divide ratio from 1 to 128. A single free-running counter, clocked by the fast input clock, supplies the divided waveform. Divide-by-1 is a bypass path that passes the input clock straight through.

The requested code may change at any time. A two-state controller (`ST_RUN`, `ST_ALIGN`) does not apply a new ratio at once. It waits for an input edge at which the counter is aligned to the slower of the old and new ratios. At that edge both ratios agree that a new period begins. Every output phase is therefore a whole phase of either the old or the new setting. Transitions: `ST_RUN` goes to `ST_ALIGN` when the requested code differs from the applied one. `ST_ALIGN` goes back to `ST_RUN` on *commit*, when the alignment point is reached and the requested code is adopted. It also goes back on *cancel*, when the request returns to the applied code. The bypass select is re-timed on the falling input edge, so it changes only while the output is low.

Top module: `glitchless_prescaler`

## Requirements
- R1: In steady state, code k (0 to 7) gives an output period of 2^k input cycles. For k of 1 or more, the high and low phases are each 2^(k-1) cycles and the period starts with the high phase. Code 0 passes the input clock through unchanged.
- R2: After reset, the applied code is 0 (bypass), so the output follows the input clock, and `switch_pending` is low.
- R3: While the ratio changes between two divided settings, every high and every low phase of the output lasts a whole half-period of either the old or the new setting. No runt phase occurs.
- R4: A new ratio is applied at an input edge where the counter is aligned to the larger of the two codes K. `switch_pending` clears no later than 2^K input cycles after it was first seen high.
- R5: `switch_pending` is high from the first input edge after the requested code differs from the applied code, and it stays high until the ratio is applied.
- R6: Requesting the code already applied raises no `switch_pending` and leaves the output period unchanged.
- R7: If the request returns to the applied code before a commit, `switch_pending` drops at the next input edge and the output keeps its ratio with no altered phase.
- R8: Entering or leaving the bypass is glitch-free. The bypass select changes only while the divided output is low, and every phase is a half-period of the old or new setting (half an input cycle for the bypass).
- R9: If the request changes again while a change is pending, the code present at the commit edge is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 3 | Requested ratio code, divide by 2^code |
| clk_out | output | 1 | Divided system clock |
| switch_pending | output | 1 | High while a requested ratio is not yet applied |

## Verification
The bench times every edge of the output clock. It flags any phase that is not a half-period of the old or new ratio. This is how a design that switched at an unaligned counter value would show up: it would emit a short runt phase. Changes into and out of the bypass are exercised in both directions. A bypass select that changed while the input clock or the divided output was high would show up as a half-cycle spike. Two timing corner cases are also covered. In the first, a request is withdrawn after one cycle; a design without cancel would still move to the withdrawn ratio. In the second, a request is replaced while pending; a design that latched the first code would settle at the wrong period.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
    parameter int unsigned DEF_CODE_W = 3;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ALIGN = 1'b1
    } psc_state_e;
endpackage

// File: rtl/psc_counter.sv
`timescale 1ns/1ps
module psc_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_nx
);
    logic [CNT_W-1:0] cnt_q;

    // value the counter takes at the coming edge
    always_comb cnt_nx = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/psc_ctrl.sv
`timescale 1ns/1ps
module psc_ctrl
    import psc_pkg::*;
#(
    parameter int unsigned CODE_W = 3,
    localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    input  logic [CNT_W-1:0]  cnt_nx,
    output logic [CODE_W-1:0] k_cur,
    output logic              pending
);
    psc_state_e        state_q, state_d;
    logic [CODE_W-1:0] k_q, k_d;
    logic [CODE_W-1:0] k_max;
    logic [CNT_W-1:0]  mask;
    logic [CNT_W-1:0]  look;
    logic              aligned;

    // alignment: the edge after this one starts a period of the slower ratio
    always_comb begin
        k_max   = (k_q > div_code) ? k_q : div_code;
        mask    = (CNT_W'(1) << k_max) - CNT_W'(1);
        look    = cnt_nx + CNT_W'(1);
        aligned = ((look & mask) == '0);
    end

    always_comb begin
        state_d = state_q;
        k_d     = k_q;
        unique case (state_q)
            ST_RUN: begin
                if (div_code != k_q) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (div_code == k_q) begin
                    state_d = ST_RUN;              // cancel
                end else if (aligned) begin
                    k_d     = div_code;            // commit
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            k_q     <= k_d;
        end
    end

    always_comb begin
        pending = (state_q == ST_ALIGN);
        k_cur   = k_q;
    end

    // R5: when pending drops, the applied code equals the code seen at that edge
    assert_pending_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> (k_q == $past(div_code)))
        else $error("pending cleared with wrong applied code");
endmodule

// File: rtl/psc_outstage.sv
`timescale 1ns/1ps
module psc_outstage #(
    parameter int unsigned CODE_W = 3,
    localparam int unsigned CNT_W = (1 << CODE_W) - 1,
    localparam int unsigned NCODE = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] k_cur,
    input  logic [CNT_W-1:0]  cnt_nx,
    output logic              clk_out
);
    logic tap;
    logic div_q;
    logic byp_lat;

    // high-first phase: output is high while the tapped bit is zero
    always_comb begin
        tap = 1'b0;
        for (int i = 1; i < NCODE; i++) begin
            if (k_cur == CODE_W'(i)) tap = ~cnt_nx[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= tap;
    end

    // bypass select re-timed while the input clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) byp_lat <= 1'b1;
        else        byp_lat <= (k_cur == '0);
    end

    always_comb clk_out = byp_lat ? clk : div_q;

    // R8: bypass select moves only while the divided output is low
    assert_bypass_swap_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_lat != $past(byp_lat)) |-> !div_q)
        else $error("bypass select changed with divided output high");

    // R1: divided path stays quiet while bypass is applied
    assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(k_cur) == '0) |-> !div_q)
        else $error("divided output active during bypass");

    // R4: a commit to a divided ratio starts the new period with a high phase
    assert_commit_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((k_cur != $past(k_cur)) && (k_cur != '0)) |=> div_q)
        else $error("new ratio did not start at a period boundary");
endmodule

// File: rtl/glitchless_prescaler.sv
`timescale 1ns/1ps
module glitchless_prescaler #(
    parameter int unsigned CODE_W = psc_pkg::DEF_CODE_W,
    localparam int unsigned CNT_W = (1 << CODE_W) - 1
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              clk_out,
    output logic              switch_pending
);
    logic [CNT_W-1:0]  cnt_nx;
    logic [CODE_W-1:0] k_cur;

    psc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .cnt_nx (cnt_nx)
    );

    psc_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .div_code (div_code),
        .cnt_nx   (cnt_nx),
        .k_cur    (k_cur),
        .pending  (switch_pending)
    );

    psc_outstage #(.CODE_W(CODE_W)) u_out (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .k_cur   (k_cur),
        .cnt_nx  (cnt_nx),
        .clk_out (clk_out)
    );
endmodule

// File: tb/sim_glitchless_prescaler.sv
`timescale 1ns/1ps
module sim_glitchless_prescaler;
    localparam int NV     = 10;
    localparam int WD_CYC = 100000;

    typedef struct packed {
        logic [2:0] code;
        logic [7:0] per;   // expected period in input cycles
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{3'd3, 8'd8},  '{3'd1, 8'd2},  '{3'd7, 8'd128}, '{3'd0, 8'd1},
        '{3'd2, 8'd4},  '{3'd5, 8'd32}, '{3'd5, 8'd32},  '{3'd4, 8'd16},
        '{3'd0, 8'd1},  '{3'd1, 8'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] div_code = 3'd0;
    logic       clk_out;
    logic       pending;

    int     tests = 0;
    int     fails = 0;
    bit     done = 0;
    bit     mon_on = 0;
    bit     have_edge = 0;
    int     glitch_err = 0;
    longint ha = 10, hb = 10, hc = 10;
    longint last_edge = 0, prev_rise = 0, last_rise = 0, bad_w = 0;
    int     cur = 0;

    glitchless_prescaler u0 (
        .clk_in         (clk),
        .rst_n          (rst_n),
        .div_code       (div_code),
        .clk_out        (clk_out),
        .switch_pending (pending)
    );

    always #10 clk = ~clk;

    function automatic longint half_ns(int k);
        return (k == 0) ? 64'd10 : longint'(1 << (k - 1)) * 20;
    endfunction

    // edge-width monitor on the output clock
    always @(clk_out) begin
        if (mon_on) begin
            if (have_edge) begin
                if (($time - last_edge) != ha && ($time - last_edge) != hb &&
                    ($time - last_edge) != hc) begin
                    glitch_err++;
                    bad_w = $time - last_edge;
                end
            end
            have_edge = 1;
            last_edge = $time;
            if (clk_out) begin
                prev_rise = last_rise;
                last_rise = $time;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic set_allowed(input int a, input int b, input int c);
        ha = half_ns(a); hb = half_ns(b); hc = half_ns(c);
    endtask

    task automatic check_bypass_state(input string tag);
        @(posedge clk); #5;
        chk(clk_out == 1'b1, tag, clk_out, 1);
        chk(pending == 1'b0, tag, pending, 0);
        @(negedge clk); #5;
        chk(clk_out == 1'b0, tag, clk_out, 0);
    endtask

    task automatic wait_settle(input int lim, output int n);
        n = 0;
        while (pending && n <= lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R2: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        have_edge = 0;
        set_allowed(0, 0, 0);
        mon_on = 1;
        check_bypass_state("R2 reset bypass");

        // table of ratio changes
        for (int i = 0; i < NV; i++) begin
            automatic int     nw  = int'(VEC[i].code);
            automatic int     kmx = (nw > cur) ? nw : cur;
            automatic string  gtag = (nw == 0 || cur == 0) ? "R8 phase width" : "R3 phase width";
            set_allowed(cur, nw, nw);
            glitch_err = 0;
            @(negedge clk);
            div_code = 3'(nw);
            @(negedge clk);
            if (nw != cur) begin
                chk(pending == 1'b1, "R5 pending raised", pending, 1);
                wait_settle((1 << kmx) + 4, n);
                chk(n <= (1 << kmx), "R4 settle bound", n, 1 << kmx);
            end else begin
                chk(pending == 1'b0, "R6 no pending on same code", pending, 0);
                repeat (2) @(negedge clk);
                chk(pending == 1'b0, "R6 still idle", pending, 0);
            end
            repeat (2) @(negedge clk);
            set_allowed(nw, nw, nw);
            repeat (3 * int'(VEC[i].per) + 4) @(negedge clk);
            chk(glitch_err == 0, gtag, bad_w, half_ns(nw));
            chk((last_rise - prev_rise) == longint'(VEC[i].per) * 20, "R1 steady period",
                last_rise - prev_rise, longint'(VEC[i].per) * 20);
            cur = nw;
        end

        // R7: request withdrawn after one cycle (applied code is 1)
        set_allowed(1, 1, 1);
        glitch_err = 0;
        @(negedge clk);
        div_code = 3'd7;
        @(negedge clk);
        chk(pending == 1'b1, "R7 pending raised", pending, 1);
        div_code = 3'd1;
        @(negedge clk);
        chk(pending == 1'b0, "R7 cancel next edge", pending, 0);
        repeat (10) @(negedge clk);
        chk(glitch_err == 0, "R7 no altered phase", bad_w, half_ns(1));
        chk((last_rise - prev_rise) == 40, "R7 ratio kept", last_rise - prev_rise, 40);

        // R9: request replaced while pending
        set_allowed(1, 6, 7);
        glitch_err = 0;
        @(negedge clk);
        div_code = 3'd7;
        @(negedge clk);
        div_code = 3'd6;
        wait_settle(300, n);
        chk(pending == 1'b0, "R9 settled", pending, 0);
        repeat (2) @(negedge clk);
        set_allowed(6, 6, 6);
        repeat (3 * 64 + 4) @(negedge clk);
        chk(glitch_err == 0, "R9 phase width", bad_w, half_ns(6));
        chk((last_rise - prev_rise) == 1280, "R9 latest code applied", last_rise - prev_rise, 1280);

        // R2: reset during divided operation
        @(negedge clk);
        mon_on = 0;
        rst_n = 1'b0;
        div_code = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        have_edge = 0;
        set_allowed(0, 0, 0);
        mon_on = 1;
        check_bypass_state("R2 reset mid-run");
        repeat (4) @(negedge clk);
        chk((last_rise - prev_rise) == 20, "R2 bypass period after reset", last_rise - prev_rise, 20);

        finish_run();
    end
endmodule